// File: doc/BRIEF.md
# ATM HEC Insert, Check-Byte Handling and Error Injection

This block sits on the transmit cell path between the system side and the line side and owns the fifth byte of every ATM cell, the header error control (HEC) byte. Cells cross it one byte per transfer on valid/ready handshakes, with a start-of-cell flag on the first byte. The system side may deliver cells with the HEC byte already present (53 bytes) or without it (52 bytes). In the second case the block computes the HEC over the four header bytes and inserts it, stalling the input for the one cycle in which the inserted byte goes out. When a HEC is supplied, it is either forwarded untouched or replaced by a freshly computed value.

For line testing, an 8-bit error mask can be XORed onto the outgoing HEC. The corruption is applied either to a single cell after a one-cycle request, or periodically to one cell in every N, with a 16-bit N where zero switches periodic injection off. A separate receive path forwards 53-byte cells from the line side to the system side and, depending on a configuration bit, keeps or removes the HEC byte.

Top module: `hec_cell_proc`

## Requirements
- R1: After reset no output is valid on either path, and the first byte sent on each path afterwards is flagged as the start of a cell.
- R2: With `cfg_tx_hec_present`=0, each 52-byte input cell leaves as a 53-byte cell whose byte at index 4 is the CRC-8 of bytes 0..3 (generator x^8+x^2+x+1, register cleared to zero, most significant bit first) XORed with 0x55. All other bytes keep their order.
- R3: While the computed HEC is being inserted, `tx_in_ready` is low, and no input byte is lost or duplicated.
- R4: With `cfg_tx_hec_present`=1 and `cfg_tx_hec_overwrite`=0, the supplied byte at index 4 is forwarded unchanged.
- R5: With `cfg_tx_hec_present`=1 and `cfg_tx_hec_overwrite`=1, the supplied byte at index 4 is replaced by the computed HEC of R2.
- R6: On a cell chosen for corruption, the outgoing HEC, whether computed or passed through, is XORed with `cfg_err_mask`.
- R7: A one-cycle pulse on `err_single_req` corrupts the HEC of the next cell only. Later cells are clean.
- R8: When `cfg_err_period`=N is nonzero, the N-th, 2N-th, ... cells counted from the enable are corrupted. When N=0, no periodic corruption occurs and the cell count is held at zero.
- R9: With `cfg_rx_keep_hec`=1, each 53-byte receive cell is delivered unchanged.
- R10: With `cfg_rx_keep_hec`=0, the receive byte at index 4 is consumed (`rx_in_ready` high) without being delivered, so 52 bytes leave.
- R11: On both paths the start-of-cell output marks exactly byte 0 of each outgoing cell. An input byte flagged as start of cell is taken as byte 0.
- R12: When the output ready is low, the output holds its byte and nothing is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tx_hec_present | input | 1 | Transmit cells from the system side carry a HEC byte |
| cfg_tx_hec_overwrite | input | 1 | Replace a supplied HEC with the computed one |
| cfg_err_mask | input | 8 | XOR pattern applied to a corrupted HEC |
| cfg_err_period | input | 16 | Corrupt one cell in this many; 0 disables |
| err_single_req | input | 1 | Pulse: corrupt the next cell's HEC once |
| tx_in_valid | input | 1 | System-side transmit byte valid |
| tx_in_sop | input | 1 | System-side transmit byte is cell byte 0 |
| tx_in_data | input | 8 | System-side transmit byte |
| tx_in_ready | output | 1 | Transmit input accepted |
| tx_out_valid | output | 1 | Line-side transmit byte valid |
| tx_out_sop | output | 1 | Line-side transmit byte is cell byte 0 |
| tx_out_data | output | 8 | Line-side transmit byte |
| tx_out_ready | input | 1 | Line side accepts the byte |
| cfg_rx_keep_hec | input | 1 | Keep the HEC byte on receive cells |
| rx_in_valid | input | 1 | Line-side receive byte valid |
| rx_in_sop | input | 1 | Line-side receive byte is cell byte 0 |
| rx_in_data | input | 8 | Line-side receive byte |
| rx_in_ready | output | 1 | Receive input accepted |
| rx_out_valid | output | 1 | System-side receive byte valid |
| rx_out_sop | output | 1 | System-side receive byte is cell byte 0 |
| rx_out_data | output | 8 | System-side receive byte |
| rx_out_ready | input | 1 | System side accepts the byte |

## Verification
On every cycle the assertions check the local timing rules. The inserted HEC byte advances the transmit position without taking input, and it stays offered under back-pressure. Both position counters wrap to byte 0 after the last byte. A pending single-shot request clears once its cell has gone out. The periodic counter stays below the period, and a receive byte that is not discarded is never accepted while the system side stalls. What only the bench's scenarios show is that the byte values are correct: the HEC against an independently computed CRC, the choice between pass-through and overwrite, the mask landing on exactly the N-th cells or the single requested cell, and the intact payload after insertion, stripping and back-pressure.

// File: rtl/hec_pkg.sv
package hec_pkg;
  localparam int          BYTE_W    = 8;
  localparam logic [7:0]  HEC_COSET = 8'h55;
  localparam logic [7:0]  HEC_GEN   = 8'h07;  // x^2+x+1, x^8 implicit

  // one byte of CRC-8 update, most significant bit first
  function automatic logic [7:0] crc8_step(input logic [7:0] crc_in,
                                           input logic [7:0] din);
    logic [7:0] c;
    logic       fb;
    c = crc_in;
    for (int i = 7; i >= 0; i--) begin
      fb = c[7] ^ din[i];
      c  = {c[6:0], 1'b0} ^ (fb ? HEC_GEN : 8'h00);
    end
    return c;
  endfunction
endpackage

// File: rtl/hec_err_sched.sv
module hec_err_sched #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period,
  input  logic             single_req,
  input  logic             fire,
  output logic             corrupt
);
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             per_on, due;

  always_comb begin
    per_on  = (period != '0);
    due     = per_on && (cnt_q >= period - 1'b1);
    corrupt = pend_q || due;
    pend_d  = single_req | (pend_q & ~fire);
    cnt_d   = cnt_q;
    if (!per_on)   cnt_d = '0;
    else if (fire) cnt_d = due ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  p_single_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && fire && !single_req) |=> !pend_q);
  p_period_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && per_on) |=> (cnt_q < $past(period)));
endmodule

// File: rtl/hec_tx_path.sv
module hec_tx_path
  import hec_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  parameter int HDR_BYTES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_hec_present,
  input  logic              cfg_hec_overwrite,
  input  logic [BYTE_W-1:0] err_mask,
  input  logic              corrupt,
  output logic              hec_fire,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic              out_sop,
  output logic [BYTE_W-1:0] out_data,
  input  logic              out_ready
);
  localparam int               POS_W = $clog2(CELL_BYTES);
  localparam logic [POS_W-1:0] HEC_P = POS_W'(HDR_BYTES);
  localparam logic [POS_W-1:0] LAST_P = POS_W'(CELL_BYTES - 1);

  logic [POS_W-1:0]  pos_q, pos_d, cur_pos;
  logic [BYTE_W-1:0] crc_q, crc_d, hec_calc, err_byte;
  logic              ins, is_hec, xfer;

  always_comb begin
    ins      = (pos_q == HEC_P) && !cfg_hec_present;
    cur_pos  = (!ins && in_sop) ? '0 : pos_q;
    is_hec   = (cur_pos == HEC_P);
    hec_calc = crc_q ^ HEC_COSET;
    err_byte = corrupt ? err_mask : '0;
    if (ins) begin
      out_valid = 1'b1;
      in_ready  = 1'b0;
      out_data  = hec_calc ^ err_byte;
    end else begin
      out_valid = in_valid;
      in_ready  = out_ready;
      out_data  = is_hec ? ((cfg_hec_overwrite ? hec_calc : in_data) ^ err_byte)
                         : in_data;
    end
    out_sop  = (cur_pos == '0);
    xfer     = out_valid && out_ready;
    hec_fire = xfer && is_hec;
    pos_d    = pos_q;
    crc_d    = crc_q;
    if (xfer) begin
      pos_d = (cur_pos == LAST_P) ? '0 : cur_pos + 1'b1;
      if (cur_pos < HEC_P)
        crc_d = crc8_step((cur_pos == '0) ? 8'h00 : crc_q, in_data);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      crc_q <= '0;
    end else begin
      pos_q <= pos_d;
      crc_q <= crc_d;
    end
  end

  p_insert_no_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ins && out_ready) |=> (pos_q == HEC_P + 1'b1));
  p_insert_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ins && !out_ready) |=> out_valid);
  p_cell_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && cur_pos == LAST_P) |=> (pos_q == '0));
endmodule

// File: rtl/hec_rx_strip.sv
module hec_rx_strip
  import hec_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  parameter int HDR_BYTES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_keep_hec,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic              out_sop,
  output logic [BYTE_W-1:0] out_data,
  input  logic              out_ready
);
  localparam int               POS_W = $clog2(CELL_BYTES);
  localparam logic [POS_W-1:0] HEC_P = POS_W'(HDR_BYTES);
  localparam logic [POS_W-1:0] LAST_P = POS_W'(CELL_BYTES - 1);

  logic [POS_W-1:0] pos_q, pos_d, cur_pos;
  logic             drop, take;

  always_comb begin
    cur_pos   = in_sop ? '0 : pos_q;
    drop      = !cfg_keep_hec && (cur_pos == HEC_P);
    out_valid = in_valid && !drop;
    in_ready  = drop ? 1'b1 : out_ready;
    out_data  = in_data;
    out_sop   = (cur_pos == '0);
    take      = in_valid && in_ready;
    pos_d     = pos_q;
    if (take) pos_d = (cur_pos == LAST_P) ? '0 : cur_pos + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  p_no_loss_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !drop && !out_ready) |-> !in_ready);
  p_rx_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cur_pos == LAST_P) |=> (pos_q == '0));
endmodule

// File: rtl/hec_cell_proc.sv
module hec_cell_proc
  import hec_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  parameter int HDR_BYTES  = 4,
  parameter int PER_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_tx_hec_present,
  input  logic              cfg_tx_hec_overwrite,
  input  logic [BYTE_W-1:0] cfg_err_mask,
  input  logic [PER_W-1:0]  cfg_err_period,
  input  logic              err_single_req,
  input  logic              tx_in_valid,
  input  logic              tx_in_sop,
  input  logic [BYTE_W-1:0] tx_in_data,
  output logic              tx_in_ready,
  output logic              tx_out_valid,
  output logic              tx_out_sop,
  output logic [BYTE_W-1:0] tx_out_data,
  input  logic              tx_out_ready,
  input  logic              cfg_rx_keep_hec,
  input  logic              rx_in_valid,
  input  logic              rx_in_sop,
  input  logic [BYTE_W-1:0] rx_in_data,
  output logic              rx_in_ready,
  output logic              rx_out_valid,
  output logic              rx_out_sop,
  output logic [BYTE_W-1:0] rx_out_data,
  input  logic              rx_out_ready
);
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  logic       corrupt, hec_fire;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  hec_err_sched #(.PER_W(PER_W)) u_sched (
    .clk(clk), .rst_n(rst_sync_n), .period(cfg_err_period),
    .single_req(err_single_req), .fire(hec_fire), .corrupt(corrupt));

  hec_tx_path #(.CELL_BYTES(CELL_BYTES), .HDR_BYTES(HDR_BYTES)) u_tx (
    .clk(clk), .rst_n(rst_sync_n),
    .cfg_hec_present(cfg_tx_hec_present), .cfg_hec_overwrite(cfg_tx_hec_overwrite),
    .err_mask(cfg_err_mask), .corrupt(corrupt), .hec_fire(hec_fire),
    .in_valid(tx_in_valid), .in_sop(tx_in_sop), .in_data(tx_in_data),
    .in_ready(tx_in_ready), .out_valid(tx_out_valid), .out_sop(tx_out_sop),
    .out_data(tx_out_data), .out_ready(tx_out_ready));

  hec_rx_strip #(.CELL_BYTES(CELL_BYTES), .HDR_BYTES(HDR_BYTES)) u_rx (
    .clk(clk), .rst_n(rst_sync_n), .cfg_keep_hec(cfg_rx_keep_hec),
    .in_valid(rx_in_valid), .in_sop(rx_in_sop), .in_data(rx_in_data),
    .in_ready(rx_in_ready), .out_valid(rx_out_valid), .out_sop(rx_out_sop),
    .out_data(rx_out_data), .out_ready(rx_out_ready));

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($rose(rst_sync_n) && !tx_in_valid) |-> !tx_out_valid);
endmodule

// File: tb/hec_cell_proc_tb.sv
module hec_cell_proc_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_tx_hec_present, cfg_tx_hec_overwrite, cfg_rx_keep_hec;
  logic [7:0]  cfg_err_mask;
  logic [15:0] cfg_err_period;
  logic        err_single_req;
  logic        tx_in_valid, tx_in_sop, tx_in_ready;
  logic [7:0]  tx_in_data, tx_out_data;
  logic        tx_out_valid, tx_out_sop, tx_out_ready;
  logic        rx_in_valid, rx_in_sop, rx_in_ready;
  logic [7:0]  rx_in_data, rx_out_data;
  logic        rx_out_valid, rx_out_sop, rx_out_ready;

  int nchk = 0;
  int nerr = 0;
  logic bp_en = 1'b0;
  logic [7:0] bp_cnt = 8'h00;

  always #10 clk = ~clk;  // 50 MHz

  hec_cell_proc u_dut (.*);

  // transmit and receive output capture rings, sampled mid-cycle
  logic [7:0] tbuf [0:63];
  logic       tsop [0:63];
  logic [7:0] rbuf [0:63];
  logic       rsop [0:63];
  int tcnt = 0;
  int rcnt = 0;

  always @(negedge clk) begin
    if (tx_out_valid && tx_out_ready) begin
      tbuf[tcnt % 64] <= tx_out_data;
      tsop[tcnt % 64] <= tx_out_sop;
      tcnt <= tcnt + 1;
    end
    if (rx_out_valid && rx_out_ready) begin
      rbuf[rcnt % 64] <= rx_out_data;
      rsop[rcnt % 64] <= rx_out_sop;
      rcnt <= rcnt + 1;
    end
  end

  // line-side back-pressure pattern
  always begin
    @(posedge clk);
    #2;
    tx_out_ready = bp_en ? (bp_cnt[0] ^ bp_cnt[2]) : 1'b1;
    bp_cnt = bp_cnt + 8'd1;
  end

  // {header[31:0], hec_present, overwrite, supplied_hec[7:0]}
  localparam logic [41:0] TX_VEC [0:5] = '{
    {32'h0000_0001, 1'b0, 1'b0, 8'h00},
    {32'h1234_5678, 1'b0, 1'b0, 8'h00},
    {32'h0000_0001, 1'b1, 1'b0, 8'hAB},
    {32'h0000_0001, 1'b1, 1'b1, 8'hAB},
    {32'hDEAD_BEEF, 1'b1, 1'b1, 8'h00},
    {32'hFFFF_FFFF, 1'b1, 1'b0, 8'h52}
  };

  // reference HEC by long division of header*x^8 by the generator
  function automatic logic [7:0] hec_ref(input logic [31:0] h);
    logic [39:0] r;
    r = {h, 8'h00};
    for (int i = 39; i >= 8; i--)
      if (r[i]) r[i -: 9] = r[i -: 9] ^ 9'h107;
    return r[7:0] ^ 8'h55;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tx_byte(input logic [7:0] d, input logic sop);
    logic acc;
    tx_in_valid = 1'b1; tx_in_data = d; tx_in_sop = sop;
    do begin
      @(negedge clk); acc = tx_in_ready;
      @(posedge clk); #1;
    end while (!acc);
    tx_in_valid = 1'b0; tx_in_sop = 1'b0;
  endtask

  task automatic rx_byte(input logic [7:0] d, input logic sop);
    logic acc;
    rx_in_valid = 1'b1; rx_in_data = d; rx_in_sop = sop;
    do begin
      @(negedge clk); acc = rx_in_ready;
      @(posedge clk); #1;
    end while (!acc);
    rx_in_valid = 1'b0; rx_in_sop = 1'b0;
  endtask

  // send one transmit cell and check what leaves the line side
  task automatic tx_cell(input logic [31:0] hdr, input logic with_hec,
                         input logic [7:0] sup, input logic [7:0] seed,
                         input logic [7:0] exp_hec, input string req);
    int start, bad;
    start = tcnt;
    for (int k = 0; k < 4; k++) tx_byte(hdr[31-8*k -: 8], k == 0);
    if (with_hec) tx_byte(sup, 1'b0);
    for (int k = 0; k < 48; k++) tx_byte(seed + 8'(3*k), 1'b0);
    for (int w = 0; w < 100 && (tcnt - start) < 53; w++) begin
      @(posedge clk); #1;
    end
    repeat (3) @(posedge clk);
    #1;
    check(tcnt - start == 53, {req, " length"}, tcnt - start, 53);
    check(tbuf[(start + 4) % 64] == exp_hec, {req, " HEC"}, tbuf[(start + 4) % 64], exp_hec);
    bad = 0;
    for (int k = 0; k < 53; k++) begin
      if (tsop[(start + k) % 64] != (k == 0)) bad++;
      if (k < 4 && tbuf[(start + k) % 64] != hdr[31-8*k -: 8]) bad++;
      if (k > 4 && tbuf[(start + k) % 64] != seed + 8'(3*(k-5))) bad++;
    end
    check(bad == 0, {req, " R11 R3 body and start flag"}, bad, 0);
  endtask

  task automatic rx_cell(input logic [31:0] hdr, input logic [7:0] seed,
                         input int exp_len, input logic [7:0] exp_b4, input string req);
    int start, bad;
    start = rcnt;
    for (int k = 0; k < 4; k++) rx_byte(hdr[31-8*k -: 8], k == 0);
    rx_byte(8'h5A, 1'b0);
    for (int k = 0; k < 48; k++) rx_byte(seed + 8'(5*k), 1'b0);
    repeat (3) @(posedge clk);
    #1;
    check(rcnt - start == exp_len, {req, " length"}, rcnt - start, exp_len);
    check(rbuf[(start + 4) % 64] == exp_b4, {req, " byte 4"}, rbuf[(start + 4) % 64], exp_b4);
    bad = 0;
    for (int k = 0; k < exp_len; k++)
      if (rsop[(start + k) % 64] != (k == 0)) bad++;
    check(bad == 0, {req, " R11 start flag"}, bad, 0);
  endtask

  initial begin
    #(20 * 150000);
    nerr++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_tx_hec_present = 1'b0; cfg_tx_hec_overwrite = 1'b0; cfg_rx_keep_hec = 1'b1;
    cfg_err_mask = 8'h00; cfg_err_period = 16'd0; err_single_req = 1'b0;
    tx_in_valid = 1'b0; tx_in_sop = 1'b0; tx_in_data = 8'h00;
    rx_in_valid = 1'b0; rx_in_sop = 1'b0; rx_in_data = 8'h00; rx_out_ready = 1'b1;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    @(negedge clk);
    check(!tx_out_valid, "R1 tx idle after reset", tx_out_valid, 0);
    check(!rx_out_valid, "R1 rx idle after reset", rx_out_valid, 0);
    @(posedge clk); #1;
    check(hec_ref(32'h0000_0001) == 8'h52, "R2 reference HEC", hec_ref(32'h1), 8'h52);

    // table walk: HEC insertion, pass-through and overwrite
    for (int v = 0; v < 6; v++) begin
      logic [7:0] e;
      cfg_tx_hec_present   = TX_VEC[v][9];
      cfg_tx_hec_overwrite = TX_VEC[v][8];
      e = (TX_VEC[v][9] && !TX_VEC[v][8]) ? TX_VEC[v][7:0] : hec_ref(TX_VEC[v][41:10]);
      tx_cell(TX_VEC[v][41:10], TX_VEC[v][9], TX_VEC[v][7:0], 8'(v * 17),
              e, TX_VEC[v][9] ? (TX_VEC[v][8] ? "R5 vec" : "R4 vec") : "R2 vec");
    end

    // single-shot injection on a passed-through HEC
    cfg_tx_hec_present = 1'b1; cfg_tx_hec_overwrite = 1'b0; cfg_err_mask = 8'h01;
    err_single_req = 1'b1; @(posedge clk); #1; err_single_req = 1'b0;
    tx_cell(32'h0A0B_0C0D, 1'b1, 8'h40, 8'h11, 8'h41, "R7 R6 single corrupted");
    tx_cell(32'h0A0B_0C0D, 1'b1, 8'h40, 8'h12, 8'h40, "R7 single not repeated");

    // periodic injection, one cell in three, inserted HEC, back-pressure on
    cfg_tx_hec_present = 1'b0; cfg_err_mask = 8'h81; cfg_err_period = 16'd3; bp_en = 1'b1;
    for (int c = 1; c <= 6; c++)
      tx_cell(32'h0000_0001, 1'b0, 8'h00, 8'(c),
              (c % 3 == 0) ? 8'hD3 : 8'h52, "R8 R12 periodic");
    cfg_err_period = 16'd0; bp_en = 1'b0;
    tx_cell(32'h0000_0001, 1'b0, 8'h00, 8'h33, 8'h52, "R8 disabled");
    tx_cell(32'h0000_0001, 1'b0, 8'h00, 8'h34, 8'h52, "R8 disabled again");

    // realignment: a start flag mid-cell restarts the count
    tx_byte(8'hEE, 1'b1);
    tx_byte(8'hEF, 1'b0);
    tx_cell(32'hCAFE_F00D, 1'b0, 8'h00, 8'h44, hec_ref(32'hCAFE_F00D), "R11 realign");

    // receive path
    cfg_rx_keep_hec = 1'b1;
    rx_cell(32'h0102_0304, 8'h20, 53, 8'h5A, "R9 keep");
    cfg_rx_keep_hec = 1'b0;
    rx_cell(32'h0102_0304, 8'h20, 52, 8'h20, "R10 strip");

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule